// File: doc/BRIEF.md
# Deferred Floating-Point Exception Controller

This block gathers the six exception conditions that floating-point execution units can raise: invalid operation, denormal operand, divide by zero, overflow, underflow and inexact result. It keeps each one as a sticky status flag. It compares every accepted condition with its own mask bit in a control word. A set mask means the unit handles the condition with a default result. A clear mask means a software handler must be invoked.

Unmasked conditions are not reported at once. They leave a pending fault. That fault turns into a request to the handler only when the next floating-point instruction starts or an explicit wait command arrives. A wait stalls until the handler reports completion. An unmasked condition of the early class (invalid, denormal, divide by zero) also cancels the result write-back of the faulting instruction in the same cycle.

Each condition pulse carries a tag that says whether it was detected before execution or after it. A pulse whose tag does not fit its condition's class is dropped.

Top module: `fpx_exc_ctrl`

## Requirements
- R1: After reset the status flags are all zero and the control word is 037Fh, so all six masks are set: any accepted condition leaves fault_req, stall and wb_kill low.
- R2: Condition bit positions are 0 invalid, 1 denormal, 2 divide by zero, 3 overflow, 4 underflow, 5 inexact. Bits 0 to 2 are accepted only with exc_pre=1 and bits 3 to 5 only with exc_pre=0. A pulse with the other tag sets no flag and raises no fault.
- R3: An accepted condition sets its status flag from the next cycle on. The flag stays set until a clear.
- R4: flag_clr zeroes the flags from the next cycle on. A condition accepted in the same cycle as the clear is still set.
- R5: Mask bits are control-word bits 0 to 5, in the bit order of R2. cw_we loads the whole word. The new masks apply to conditions from the next cycle on.
- R6: wb_kill is high in the same cycle as an accepted unmasked condition of bits 0 to 2. Conditions of bits 3 to 5 never raise it.
- R7: An accepted unmasked condition makes a fault pending from the next cycle. fault_req rises in the cycle after a cycle in which a fault is already pending and instr_start or wait_req is high. It then stays high until handler_done.
- R8: wait_req in a cycle with a pending fault raises stall in that same cycle. Stall stays high until the cycle after handler_done. wait_req with no pending fault does not stall.
- R9: handler_done clears the pending fault, fault_req and stall from the next cycle on. An unmasked condition accepted in the same cycle makes a new fault pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_we | input | 1 | Control-word write strobe |
| cw_wdata | input | CW_W | Control-word write data |
| exc_vld | input | 6 | Condition pulses, one bit per condition |
| exc_pre | input | 1 | Tag: 1 = detected before execution, 0 = after |
| flag_clr | input | 1 | Clear all status flags |
| instr_start | input | 1 | A floating-point instruction is about to start |
| wait_req | input | 1 | Explicit wait command |
| handler_done | input | 1 | Software handler finished |
| stat_flags | output | 6 | Sticky status flags |
| fault_req | output | 1 | Request to run the handler |
| stall | output | 1 | Hold issue while the wait is unserved |
| wb_kill | output | 1 | Cancel the write-back of the current instruction |

## Verification
A wrong sticky flag appears on stat_flags one cycle after the pulse or clear that caused it. A bad mask or class decode shows at once on wb_kill. A lost or phantom pending fault only becomes visible when the next instr_start or wait_req arrives: it then shows as a missing or spurious fault_req one cycle later, or as a stall level in that same cycle. For this reason the bench issues these strobes often, both with a fault pending and with none, and compares every output with a behavioural model on every clock.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int EXC_N = 6;
   typedef enum int {
      EX_INV = 0,
      EX_DEN = 1,
      EX_DZ  = 2,
      EX_OVF = 3,
      EX_UND = 4,
      EX_INX = 5
   } exc_idx_e;
   // conditions detected before execution
   localparam logic [EXC_N-1:0] EARLY_CLASS = 6'b000111;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify #(
   parameter int               N     = 6,
   parameter logic [N-1:0]     EARLY = '0
) (
   input  logic [N-1:0] exc_vld,
   input  logic         exc_pre,
   input  logic [N-1:0] mask,
   output logic [N-1:0] acc,
   output logic [N-1:0] unm_early,
   output logic [N-1:0] unm_late
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_bit
         if (EARLY[g]) begin : g_early
            assign acc[g]       = exc_vld[g] & exc_pre;
            assign unm_early[g] = acc[g] & ~mask[g];
            assign unm_late[g]  = 1'b0;
         end else begin : g_late
            assign acc[g]       = exc_vld[g] & ~exc_pre;
            assign unm_early[g] = 1'b0;
            assign unm_late[g]  = acc[g] & ~mask[g];
         end
      end
   endgenerate
endmodule

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] flag_q
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)     flag_q[g] <= 1'b0;
            else if (set_i[g]) flag_q[g] <= 1'b1;
            else if (clr_i) flag_q[g] <= 1'b0;
         end
         AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !clr_i) |=> flag_q[g]); // R3
      end
   endgenerate
endmodule

// File: rtl/fpx_fault_seq.sv
module fpx_fault_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic new_unm,
   input  logic instr_start,
   input  logic wait_req,
   input  logic done,
   output logic pending,
   output logic fault_req,
   output logic stall
);
   logic pend_q, svc_q, wait_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         svc_q  <= 1'b0;
         wait_q <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~done) | new_unm;
         svc_q  <= done ? 1'b0 : (svc_q | (pend_q & (instr_start | wait_req)));
         wait_q <= done ? 1'b0 : (wait_q | (pend_q & wait_req));
      end
   end

   assign pending   = pend_q;
   assign fault_req = svc_q;
   assign stall     = pend_q & (wait_req | wait_q);

   AST_FAULT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      fault_req |-> pending); // R7
   AST_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |-> !stall); // R8
   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !new_unm) |=> (!fault_req && !stall && !pending)); // R9
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_req && !done) |=> fault_req); // R7
endmodule

// File: rtl/fpx_exc_ctrl.sv
module fpx_exc_ctrl #(
   parameter int              CW_W     = 16,
   parameter logic [CW_W-1:0] CW_RST   = 16'h037F,
   parameter int              MASK_LSB = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cw_we,
   input  logic [CW_W-1:0]           cw_wdata,
   input  logic [fpx_pkg::EXC_N-1:0] exc_vld,
   input  logic                      exc_pre,
   input  logic                      flag_clr,
   input  logic                      instr_start,
   input  logic                      wait_req,
   input  logic                      handler_done,
   output logic [fpx_pkg::EXC_N-1:0] stat_flags,
   output logic                      fault_req,
   output logic                      stall,
   output logic                      wb_kill
);
   import fpx_pkg::*;
   localparam int MSB = MASK_LSB + EXC_N - 1;

   generate
      if (MSB >= CW_W || MASK_LSB < 0) begin : g_bad
         $error("mask field does not fit the control word");
      end
   endgenerate

   logic [CW_W-1:0]  cw_q;
   logic [EXC_N-1:0] mask, acc, unm_early, unm_late;
   logic             pending;

   always_ff @(posedge clk) begin
      if (!rst_n)     cw_q <= CW_RST;
      else if (cw_we) cw_q <= cw_wdata;
   end
   assign mask = cw_q[MSB:MASK_LSB];

   fpx_classify #(.N(EXC_N), .EARLY(EARLY_CLASS)) i_cls (
      .exc_vld(exc_vld), .exc_pre(exc_pre), .mask(mask),
      .acc(acc), .unm_early(unm_early), .unm_late(unm_late));

   fpx_flag_bank #(.N(EXC_N)) i_flags (
      .clk(clk), .rst_n(rst_n), .set_i(acc), .clr_i(flag_clr),
      .flag_q(stat_flags));

   fpx_fault_seq i_seq (
      .clk(clk), .rst_n(rst_n), .new_unm(|(unm_early | unm_late)),
      .instr_start(instr_start), .wait_req(wait_req), .done(handler_done),
      .pending(pending), .fault_req(fault_req), .stall(stall));

   assign wb_kill = |unm_early;

   AST_KILL_EARLY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      wb_kill |-> (exc_pre && |(exc_vld & EARLY_CLASS))); // R6
   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && exc_vld == '0) |=> (stat_flags == '0)); // R4
   AST_FLAG_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_vld == '0 && !flag_clr) |=> $stable(stat_flags)); // R3
   AST_PEND_ON_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (|(acc & ~mask)) |=> pending); // R7
endmodule

// File: tb/test_fpx_exc_ctrl.sv
module test_fpx_exc_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] EARLY = 6'b000111;

   logic clk = 1'b0;
   logic rst_n, cw_we, exc_pre, flag_clr, instr_start, wait_req, handler_done;
   logic [15:0] cw_wdata;
   logic [5:0]  exc_vld, stat_flags;
   logic fault_req, stall, wb_kill;

   int n_chk = 0, n_fail = 0;

   // reference model state
   logic [15:0] m_cw;
   logic [5:0]  m_flags;
   bit m_pend, m_req, m_wait;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpx_exc_ctrl i_fpx_exc_ctrl (
      .clk(clk), .rst_n(rst_n), .cw_we(cw_we), .cw_wdata(cw_wdata),
      .exc_vld(exc_vld), .exc_pre(exc_pre), .flag_clr(flag_clr),
      .instr_start(instr_start), .wait_req(wait_req), .handler_done(handler_done),
      .stat_flags(stat_flags), .fault_req(fault_req), .stall(stall), .wb_kill(wb_kill));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] accepted();
      logic [5:0] a = '0;
      for (int i = 0; i < 6; i++)
         if (exc_vld[i] && (EARLY[i] == exc_pre)) a[i] = 1'b1;
      return a;
   endfunction

   task automatic clear_inputs();
      cw_we = 0; cw_wdata = '0; exc_vld = '0; exc_pre = 0; flag_clr = 0;
      instr_start = 0; wait_req = 0; handler_done = 0;
   endtask

   // compare all outputs to the model, then advance one clock
   task automatic tick();
      logic [5:0] a, u;
      bit e_kill, e_stall;
      #(CLK_PERIOD/4);
      a = accepted();
      u = a & ~m_cw[5:0];
      e_kill  = |(u & EARLY);
      e_stall = m_pend && (wait_req || m_wait);
      if (rst_n) begin
         chk(stat_flags == m_flags, "R3 flags", stat_flags, m_flags);
         chk(fault_req == m_req, "R7 fault_req", fault_req, m_req);
         chk(stall == e_stall, "R8 stall", stall, e_stall);
         chk(wb_kill == e_kill, "R6 wb_kill", wb_kill, e_kill);
      end
      @(posedge clk);
      if (!rst_n) begin
         m_cw = 16'h037F; m_flags = '0; m_pend = 0; m_req = 0; m_wait = 0;
      end else begin
         if (handler_done) begin
            m_req = 0; m_wait = 0;
         end else begin
            if (m_pend && (instr_start || wait_req)) m_req = 1;
            if (m_pend && wait_req) m_wait = 1;
         end
         m_pend = (m_pend && !handler_done) || (u != 0);
         if (flag_clr) m_flags = '0;
         m_flags = m_flags | a;
         if (cw_we) m_cw = cw_wdata;
      end
      @(negedge clk);
      clear_inputs();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      clear_inputs();
      rst_n = 0;
      @(negedge clk);
      repeat (3) tick();
      rst_n = 1;
      #1;
      chk(stat_flags == 6'h00, "R1 reset flags", stat_flags, 0);
      chk(!fault_req && !stall, "R1 reset fault", {fault_req, stall}, 0);
      // all masked after reset
      exc_vld = 6'h07; exc_pre = 1; #1;
      chk(!wb_kill, "R1 masked early no kill", wb_kill, 0);
      tick();
      exc_vld = 6'h38; exc_pre = 0; tick();
      instr_start = 1; wait_req = 1; #1;
      chk(!stall, "R1 masked no stall", stall, 0);
      tick(); #1;
      chk(stat_flags == 6'h3F, "R3 all flags", stat_flags, 6'h3F);
      chk(!fault_req, "R1 masked no fault", fault_req, 0);
      // clear, then wrong tags
      flag_clr = 1; tick(); #1;
      chk(stat_flags == 6'h00, "R4 clear", stat_flags, 0);
      exc_vld = 6'h01; exc_pre = 0; tick();
      exc_vld = 6'h20; exc_pre = 1; tick(); #1;
      chk(stat_flags == 6'h00, "R2 wrong tag ignored", stat_flags, 0);
      // clear and set together
      exc_vld = 6'h10; exc_pre = 0; flag_clr = 1; tick(); #1;
      chk(stat_flags == 6'h10, "R4 set wins over clear", stat_flags, 6'h10);
      // unmask divide by zero (bit 2)
      cw_we = 1; cw_wdata = 16'h037B;
      exc_vld = 6'h04; exc_pre = 1; #1;
      chk(!wb_kill, "R5 mask applies next cycle", wb_kill, 0);
      tick();
      exc_vld = 6'h04; exc_pre = 1; #1;
      chk(wb_kill, "R6 early unmasked kill", wb_kill, 1);
      tick(); #1;
      chk(!fault_req, "R7 deferred", fault_req, 0);
      tick(); tick(); #1;
      chk(!fault_req, "R7 still deferred", fault_req, 0);
      instr_start = 1; tick(); #1;
      chk(fault_req, "R7 raised on start", fault_req, 1);
      wait_req = 1; #1;
      chk(stall, "R8 wait stalls", stall, 1);
      tick(); tick(); #1;
      chk(stall, "R8 stall held", stall, 1);
      handler_done = 1; tick(); #1;
      chk(!fault_req && !stall, "R9 released", {fault_req, stall}, 0);
      wait_req = 1; #1;
      chk(!stall, "R8 idle wait no stall", stall, 0);
      tick();
      // unmask overflow (bit 3): late, no kill
      cw_we = 1; cw_wdata = 16'h0373; tick();
      exc_vld = 6'h08; exc_pre = 0; #1;
      chk(!wb_kill, "R6 late no kill", wb_kill, 0);
      tick();
      wait_req = 1; tick(); #1;
      chk(fault_req, "R7 raised on wait", fault_req, 1);
      handler_done = 1; exc_vld = 6'h08; exc_pre = 0; tick(); #1;
      chk(!fault_req, "R9 done clears req", fault_req, 0);
      instr_start = 1; tick(); #1;
      chk(fault_req, "R9 re-armed", fault_req, 1);
      handler_done = 1; tick();
      // random phase
      for (int k = 0; k < 4000; k++) begin
         exc_vld      = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h00;
         exc_pre      = 1'($urandom);
         flag_clr     = ($urandom_range(0, 15) == 0);
         instr_start  = ($urandom_range(0, 5) == 0);
         wait_req     = ($urandom_range(0, 7) == 0);
         handler_done = ($urandom_range(0, 9) == 0);
         cw_we        = ($urandom_range(0, 31) == 0);
         cw_wdata     = {10'h00D, 6'($urandom)};
         tick();
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule